// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a single-clock request port to an external asynchronous static RAM of 262,144 words of 16 bits. A requester presents a read or a write with an 18-bit word address, 16-bit write data and a two-bit lane mask. The controller turns the request into an active-low strobe sequence (chip select, read gate, write pulse and two lane selects), steers a 16-bit data bus through a drive-enable, and returns read data with a one-cycle valid pulse.

The write pulse width and the read wait are parameters counted in clocks, so the same block suits different memory speed grades and system clocks. Mask bit 0 selects the low lane (data bits 7..0), mask bit 1 the high lane (bits 15..8). A request whose mask is zero is absorbed without touching the memory. While an access runs, the ready output is low and the request inputs are ignored.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, chip select, read gate, write pulse and both lane selects are high, the bus drive-enable is low, ready is high and read-valid is low.
- R2: The bus drive-enable is never high in a cycle where the read gate is low.
- R3: The read gate only falls after a cycle in which the bus drive-enable was already low, so a read after a write leaves at least one undriven clock.
- R4: The write pulse only falls when chip select was low in the previous cycle and the address output is unchanged from that cycle.
- R5: Each write pulse stays low for exactly WR_PULSE_CLKS consecutive clocks.
- R6: In the cycle after the write pulse rises, chip select stays low and the address and write-data outputs are unchanged from the pulse, with the bus still driven.
- R7: A lane select is low during an access only when its mask bit is 1 (bit 0 drives the low-lane select for data bits 7..0, bit 1 the high-lane select for bits 15..8); a write alters only enabled lanes of the stored word.
- R8: A read holds the read gate low for RD_WAIT_CLKS clocks, samples the bus on the last of them and raises read-valid in the following cycle; bits of a lane whose mask bit is 0 read as zero.
- R9: A request with mask 00 leaves chip select high, keeps ready high and produces no read-valid.
- R10: Ready is low from the cycle after an access is accepted until it completes, and requests presented while ready is low have no effect.
- R11: Read-valid is high for exactly one cycle per read.
- R12: The write pulse and the read gate are never low together, and while chip select is high every other strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken when both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 low lane, bit 1 high lane |
| rd_valid | output | 1 | Read data valid, one-cycle pulse |
| rd_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read gate, active low |
| mem_we_n | output | 1 | Memory write pulse, active low |
| mem_ub_n | output | 1 | High-lane select, active low |
| mem_lb_n | output | 1 | Low-lane select, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive-enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory bus |

## Verification
The properties assume the requester holds its inputs steady only in the sense the port defines: a request counts at the edge where valid and ready are both high, and the memory bus input may carry any value at any time. The stimulus comes from a bench-side word store that writes on the clock when the write pulse and chip select are low and returns stored lanes only when selected and read-gated, filling unselected lanes with a fixed filler pattern so that lane masking is visible. Requests are always launched half a clock before an edge and extra requests are raised only while ready is low, so the busy-ignore case is exercised without violating the handshake.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int WORD_ADDR_W = 18;
    localparam int WORD_W      = 16;
    localparam int LANE_W      = 8;
    localparam int LANES       = WORD_W / LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_RWAIT  = 3'd4
    } ctl_state_e;

    typedef struct packed {
        logic                   write;
        logic [WORD_ADDR_W-1:0] addr;
        logic [WORD_W-1:0]      wdata;
        logic [LANES-1:0]       be;
    } req_t;

    typedef struct packed {
        logic             ce_n;
        logic             oe_n;
        logic             we_n;
        logic [LANES-1:0] lane_n;
        logic             drive;
    } strobe_t;

    function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/sram_req_fsm.sv
module sram_req_fsm
    import sram_lane_pkg::*;
#(
    parameter int WR_PULSE_CLKS = 1,
    parameter int RD_WAIT_CLKS  = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  req_t       req_in,
    output logic       ready,
    output ctl_state_e state,
    output req_t       cur,
    output logic       rd_done
);

    localparam int MAX_CLKS = (WR_PULSE_CLKS > RD_WAIT_CLKS) ? WR_PULSE_CLKS : RD_WAIT_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);

    logic [CNT_W-1:0] cnt;

    assign ready   = (state == ST_IDLE);
    assign rd_done = (state == ST_RWAIT) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cur   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid && (req_in.be != '0)) begin
                        cur <= req_in;
                        if (req_in.write) begin
                            state <= ST_WSETUP;
                        end else begin
                            state <= ST_RWAIT;
                            cnt   <= CNT_W'(RD_WAIT_CLKS - 1);
                        end
                    end
                end
                ST_WSETUP: begin
                    state <= ST_WPULSE;
                    cnt   <= CNT_W'(WR_PULSE_CLKS - 1);
                end
                ST_WPULSE: begin
                    if (cnt == '0) state <= ST_WHOLD;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_WHOLD: begin
                    state <= ST_IDLE;
                end
                ST_RWAIT: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sram_strobe_dec.sv
module sram_strobe_dec
    import sram_lane_pkg::*;
(
    input  ctl_state_e       state,
    input  logic [LANES-1:0] be,
    output strobe_t          stb
);

    logic active;
    logic writing;

    always_comb begin
        active  = (state != ST_IDLE);
        writing = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD);
        stb.ce_n  = ~active;
        stb.oe_n  = ~(state == ST_RWAIT);
        stb.we_n  = ~(state == ST_WPULSE);
        stb.drive = writing;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign stb.lane_n[g] = ~(active & be[g]);
    end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture
    import sram_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_done,
    input  logic [LANES-1:0]  be,
    input  logic [WORD_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_done;
            if (rd_done) rd_data <= dq_in & lane_mask(be);
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int WR_PULSE_CLKS = 1,
    parameter int RD_WAIT_CLKS  = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [WORD_ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0]      req_wdata,
    input  logic [LANES-1:0]       req_be,
    output logic                   rd_valid,
    output logic [WORD_W-1:0]      rd_data,
    output logic [WORD_ADDR_W-1:0] mem_addr,
    output logic                   mem_ce_n,
    output logic                   mem_oe_n,
    output logic                   mem_we_n,
    output logic                   mem_ub_n,
    output logic                   mem_lb_n,
    output logic [WORD_W-1:0]      mem_dq_out,
    output logic                   mem_dq_oe,
    input  logic [WORD_W-1:0]      mem_dq_in
);

    req_t       req_in;
    req_t       cur;
    ctl_state_e state;
    strobe_t    stb;
    logic       rd_done;

    assign req_in = '{write: req_write, addr: req_addr, wdata: req_wdata, be: req_be};

    sram_req_fsm #(
        .WR_PULSE_CLKS (WR_PULSE_CLKS),
        .RD_WAIT_CLKS  (RD_WAIT_CLKS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .ready     (req_ready),
        .state     (state),
        .cur       (cur),
        .rd_done   (rd_done)
    );

    sram_strobe_dec u_dec (
        .state (state),
        .be    (cur.be),
        .stb   (stb)
    );

    sram_rd_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .rd_done  (rd_done),
        .be       (cur.be),
        .dq_in    (mem_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign mem_addr   = cur.addr;
    assign mem_dq_out = cur.wdata;
    assign mem_ce_n   = stb.ce_n;
    assign mem_oe_n   = stb.oe_n;
    assign mem_we_n   = stb.we_n;
    assign mem_lb_n   = stb.lane_n[0];
    assign mem_ub_n   = stb.lane_n[1];
    assign mem_dq_oe  = stb.drive;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk
    import sram_lane_pkg::*;
#(
    parameter int WR_PULSE_CLKS = 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [LANES-1:0]       req_be,
    input logic                   rd_valid,
    input logic [WORD_ADDR_W-1:0] mem_addr,
    input logic                   mem_ce_n,
    input logic                   mem_oe_n,
    input logic                   mem_we_n,
    input logic                   mem_ub_n,
    input logic                   mem_lb_n,
    input logic [WORD_W-1:0]      mem_dq_out,
    input logic                   mem_dq_oe
);

    int low_cnt;

    always_ff @(posedge clk) begin
        if (rst)            low_cnt <= 0;
        else if (!mem_we_n) low_cnt <= low_cnt + 1;
        else                low_cnt <= 0;
    end

    p_reset_idle_r1: assert property (@(posedge clk) $fell(rst) |-> mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rd_valid);
    p_no_contention_r2: assert property (@(posedge clk) disable iff (rst) !mem_oe_n |-> !mem_dq_oe);
    p_turnaround_r3: assert property (@(posedge clk) disable iff (rst) $fell(mem_oe_n) |-> !$past(mem_dq_oe));
    p_we_setup_r4: assert property (@(posedge clk) disable iff (rst) $fell(mem_we_n) |-> !$past(mem_ce_n) && $stable(mem_addr));
    p_we_not_long_r5: assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> (low_cnt < WR_PULSE_CLKS));
    p_we_width_r5: assert property (@(posedge clk) disable iff (rst) $rose(mem_we_n) |-> ($past(low_cnt) == WR_PULSE_CLKS - 1));
    p_we_hold_r6: assert property (@(posedge clk) disable iff (rst) $rose(mem_we_n) |-> !mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out));
    p_lane_gate_r7: assert property (@(posedge clk) disable iff (rst) (!mem_lb_n || !mem_ub_n) |-> !mem_ce_n);
    p_rd_after_gate_r8: assert property (@(posedge clk) disable iff (rst) $rose(rd_valid) |-> !$past(mem_oe_n));
    p_zero_mask_r9: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready && req_be == '0) |=> mem_ce_n && req_ready);
    p_busy_r10: assert property (@(posedge clk) disable iff (rst) !mem_ce_n |-> !req_ready);
    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (rst) rd_valid |=> !rd_valid);
    p_no_both_r12: assert property (@(posedge clk) disable iff (rst) !(!mem_we_n && !mem_oe_n));
    p_idle_strobes_r12: assert property (@(posedge clk) disable iff (rst) mem_ce_n |-> mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.WR_PULSE_CLKS(WR_PULSE_CLKS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_be     (req_be),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_ub_n   (mem_ub_n),
    .mem_lb_n   (mem_lb_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

    localparam int WRP = 2;
    localparam int RDW = 3;

    typedef struct packed {
        logic        wr;
        logic [17:0] addr;
        logic [15:0] data;
        logic [1:0]  be;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 18'h00010, 16'h1234, 2'b11, 16'h0000},
        '{1'b0, 18'h00010, 16'h0000, 2'b11, 16'h1234},
        '{1'b1, 18'h00010, 16'hABCD, 2'b10, 16'h0000},
        '{1'b0, 18'h00010, 16'h0000, 2'b11, 16'hAB34},
        '{1'b1, 18'h00010, 16'h5566, 2'b01, 16'h0000},
        '{1'b0, 18'h00010, 16'h0000, 2'b01, 16'h0066},
        '{1'b0, 18'h00010, 16'h0000, 2'b10, 16'hAB00},
        '{1'b1, 18'h3FFFF, 16'h8001, 2'b11, 16'h0000},
        '{1'b0, 18'h3FFFF, 16'h0000, 2'b11, 16'h8001},
        '{1'b1, 18'h00000, 16'hFFFF, 2'b11, 16'h0000},
        '{1'b0, 18'h00000, 16'h0000, 2'b11, 16'hFFFF},
        '{1'b0, 18'h3FFFF, 16'h0000, 2'b11, 16'h8001}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [15:0] store [64];

    always #10 clk = ~clk;

    sram_lane_ctrl #(.WR_PULSE_CLKS(WRP), .RD_WAIT_CLKS(RDW)) i_sram_lane_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // bench-side word store; unselected lanes show filler A5
    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_lb_n) store[mem_addr[5:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) store[mem_addr[5:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    always_comb begin
        mem_dq_in = 16'hA5A5;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (!mem_lb_n) mem_dq_in[7:0]  = store[mem_addr[5:0]][7:0];
            if (!mem_ub_n) mem_dq_in[15:8] = store[mem_addr[5:0]][15:8];
        end
    end

    // bus monitors
    int contention = 0;
    int turn_bad = 0;
    int we_len = 0;
    int we_last = -1;
    int we_bad = 0;
    int valid_run = 0;
    int valid_bad = 0;
    logic prev_drive = 1'b0;
    logic prev_oe_n = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && !mem_oe_n) contention++;
            if (!mem_oe_n && prev_oe_n && prev_drive) turn_bad++;
            if (!mem_we_n) we_len++;
            else if (we_len != 0) begin
                we_last = we_len;
                if (we_len != WRP) we_bad++;
                we_len = 0;
            end
            if (rd_valid) begin
                valid_run++;
                if (valid_run > 1) valid_bad++;
            end else valid_run = 0;
            prev_drive = mem_dq_oe;
            prev_oe_n  = mem_oe_n;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic wr, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] be, output logic [15:0] rdata, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 ready low after accept", {31'd0, req_ready}, 32'd0);
        check("R4 address presented", {14'd0, mem_addr}, {14'd0, a});
        lat = 1;
        rdata = '0;
        if (!wr) begin
            while (!rd_valid && lat < 20) begin
                @(negedge clk);
                lat++;
            end
            rdata = rd_data;
        end else begin
            while (!req_ready && lat < 20) begin
                @(negedge clk);
                lat++;
            end
        end
    endtask

    initial begin
        logic [15:0] rd;
        int lat;
        for (int i = 0; i < 64; i++) store[i] = '0;

        repeat (3) @(negedge clk);
        check("R1 ce_n in reset", {31'd0, mem_ce_n}, 32'd1);
        check("R1 lanes idle in reset", {30'd0, mem_ub_n, mem_lb_n}, 32'd3);
        check("R1 drive off in reset", {31'd0, mem_dq_oe}, 32'd0);
        check("R1 ready in reset", {31'd0, req_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 strobes after reset", {29'd0, mem_oe_n, mem_we_n, rd_valid}, 32'd6);

        for (int v = 0; v < NV; v++) begin
            do_op(VECS[v].wr, VECS[v].addr, VECS[v].data, VECS[v].be, rd, lat);
            if (!VECS[v].wr) begin
                check("R8 read data", {16'd0, rd}, {16'd0, VECS[v].exp});
                check("R8 read latency", lat, RDW + 1);
            end else begin
                check("R5 write pulse width", we_last, WRP);
            end
        end

        // R9: zero mask is a no-op
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00010; req_be = 2'b00;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 ready kept", {31'd0, req_ready}, 32'd1);
        check("R9 ce_n kept high", {31'd0, mem_ce_n}, 32'd1);
        repeat (RDW + 2) begin
            @(negedge clk);
            check("R9 no read-valid", {30'd0, rd_valid, mem_ce_n}, 32'd1);
        end

        // R10: request during busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00005; req_wdata = 16'h1111; req_be = 2'b11;
        @(posedge clk);
        @(negedge clk);
        req_addr = 18'h00006; req_wdata = 16'h7777;
        check("R10 busy", {31'd0, req_ready}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        do_op(1'b0, 18'h00006, 16'h0, 2'b11, rd, lat);
        check("R10 busy request ignored", {16'd0, rd}, 32'h0000);
        do_op(1'b0, 18'h00005, 16'h0, 2'b11, rd, lat);
        check("R7 full write stored", {16'd0, rd}, 32'h1111);

        // R7: high lane only write, read low lane only
        do_op(1'b1, 18'h00005, 16'h9922, 2'b10, rd, lat);
        do_op(1'b0, 18'h00005, 16'h0, 2'b11, rd, lat);
        check("R7 high lane merge", {16'd0, rd}, 32'h9911);
        do_op(1'b0, 18'h00005, 16'h0, 2'b01, rd, lat);
        check("R8 masked high lane zero", {16'd0, rd}, 32'h0011);

        repeat (3) @(negedge clk);
        check("R2 no bus contention", contention, 0);
        check("R3 turnaround gap", turn_bad, 0);
        check("R5 all pulses width", we_bad, 0);
        check("R11 valid one cycle", valid_bad, 0);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule